// File: doc/BRIEF.md
# Serial Interface Ones-Run Reset Detector

This block sits beside the serial port of a peripheral and watches the data input. When chip select is active, every rising edge of the serial clock moves one data bit in. The block keeps count of how many of those bits have been 1 in a row. When that count reaches 40, the host has sent an in-band reset command. This is how a host recovers an interface that has lost framing, for example after a noise glitch on the serial clock. The block then drives an active-low soft reset pulse. That pulse returns the interface state machine, the filter and modulator control, and every register of the peripheral to its default. The power-on reset input produces the same pulse.

The serial clock, chip select and data lines are brought into the system clock domain through a synchronizer chain. Rising edges of the serial clock are detected there. Each qualified edge gives a one-cycle bit strobe to the downstream serial logic.

After every soft reset pulse, the block holds a busy flag for a lockout window. The window is a parameter in system clock cycles and is derived from the clock frequency and a 500 µs default. While busy is high, bit strobes are not passed on, so register transfers are ignored. The serial read line is also forced to all ones. The run detector keeps working during the lockout, so a new reset command restarts the whole sequence.

Top module: `ones_reset_guard`

## Requirements
- R1: A run of RUN_LEN (default 40) consecutive 1 bits produces one soft reset pulse. A bit is sampled on a rising serial clock edge while cs_n_i is low. The pulse drives soft_rst_n_o low for exactly RST_PULSE_CYC system clock cycles.
- R2: A 0 bit sampled with chip select active clears the run. For example, 39 ones, then a 0, then 39 ones gives no reset, and one further 1 gives a reset.
- R3: Ones beyond RUN_LEN do not produce further pulses. The run stays saturated until a 0 bit is sampled; after that, a fresh run of RUN_LEN ones produces the next pulse.
- R4: Serial clock edges seen while cs_n_i is high are neither counted nor forwarded. They neither extend nor break a run.
- R5: While rst_n is low, soft_rst_n_o is low and busy_o is high. After rst_n is released, the same pulse-then-lockout sequence as a command reset follows. busy_o is high whenever soft_rst_n_o is low.
- R6: After soft_rst_n_o rises, busy_o stays high for exactly LOCK_CYC = CLK_KHZ*LOCKOUT_US/1000 cycles and then falls.
- R7: While busy_o is high, bit_stb_o stays 0 (transfers are ignored) and sdo_o is 1.
- R8: While busy_o is low, each qualified serial clock rising edge gives exactly one single-cycle bit_stb_o pulse, with bit_o equal to the sampled data bit. In the same state, sdo_o equals core_sdo_i.
- R9: A reset command that completes during the lockout drives a new soft reset pulse. busy_o stays high without a gap, and a full LOCK_CYC window follows the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| cs_n_i | input | 1 | Serial chip select, active low |
| sdi_i | input | 1 | Serial data from the host |
| core_sdo_i | input | 1 | Read data from the downstream serial logic |
| sdo_o | output | 1 | Serial read data to the host, forced high during lockout |
| bit_stb_o | output | 1 | One-cycle strobe per accepted serial bit |
| bit_o | output | 1 | Value of the accepted serial bit |
| soft_rst_n_o | output | 1 | Soft reset to the interface, filter, modulator and registers, active low |
| busy_o | output | 1 | High during the reset pulse and the access lockout |

## Verification
The bench keeps the 40-bit run length and the 500 µs lockout. It sets the clock to 1 MHz, so the window is 500 cycles, and it uses a 4-cycle reset pulse. With these values, an exact lockout count can be measured on every reset. The window is also long enough that a complete second reset command (a 0 followed by 40 ones) fits inside it, which makes the restart case reachable. Random bit streams with occasional deselected bits are checked against a run-length model that predicts how many pulses occur.

// File: rtl/orst_pkg.sv
// Shared definitions for the ones-run reset detector.
// Assumes nothing beyond the standard language.
package orst_pkg;

    // Phases of the reset sequencer
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_LOCK  = 2'd2
    } seq_state_t;

    // Lockout length in system cycles from clock rate (kHz) and time (us)
    function automatic int lock_cycles(input int clk_khz, input int lock_us);
        return (clk_khz * lock_us) / 1000;
    endfunction

    // Larger of two counts, used to size a shared timer
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/orst_sclk_sampler.sv
// Brings serial clock, chip select and data into the system clock domain
// and emits a one-cycle strobe on each rising serial clock edge seen while
// chip select is active. Assumes SYNC_STAGES >= 2 and that the serial clock
// high and low phases each last longer than SYNC_STAGES + 1 system cycles.
module orst_sclk_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic bit_stb_o,
    output logic bit_o
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sclk_sr;
    logic [MSB:0] csn_sr;
    logic [MSB:0] sdi_sr;
    logic         sclk_last;

    // Synchronizer chains, one per input line, built stage by stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw asynchronous lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_sr[0] <= 1'b0;
                    csn_sr[0]  <= 1'b1;
                    sdi_sr[0]  <= 1'b0;
                end else begin
                    sclk_sr[0] <= sclk_i;
                    csn_sr[0]  <= cs_n_i;
                    sdi_sr[0]  <= sdi_i;
                end
            end
        end else begin : g_next
            // Later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sclk_sr[g] <= 1'b0;
                    csn_sr[g]  <= 1'b1;
                    sdi_sr[g]  <= 1'b0;
                end else begin
                    sclk_sr[g] <= sclk_sr[g-1];
                    csn_sr[g]  <= csn_sr[g-1];
                    sdi_sr[g]  <= sdi_sr[g-1];
                end
            end
        end
    end

    // Delayed copy of the synchronized serial clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_last <= 1'b0;
        end else begin
            sclk_last <= sclk_sr[MSB];
        end
    end

    // Strobe on a rising edge while selected; data is taken from the same stage
    always_comb begin
        bit_stb_o = sclk_sr[MSB] & ~sclk_last & ~csn_sr[MSB];
        bit_o     = sdi_sr[MSB];
    end

endmodule

// File: rtl/orst_run_detector.sv
// Counts consecutive 1 bits on accepted serial strobes. A 0 bit clears the
// count. The count saturates at RUN_LEN so one long run fires only once.
// Only the power-on reset clears it; the soft reset it produces does not.
// Assumes RUN_LEN >= 2.
module orst_run_detector #(
    parameter int RUN_LEN = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb_i,
    input  logic bit_i,
    output logic fire_o
);

    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] TOP  = CW'(RUN_LEN);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_q;
    logic          fire_q;

    // Run length bookkeeping: clear on a 0, climb on a 1, hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_stb_i) begin
            if (!bit_i) begin
                run_q <= '0;
            end else if (run_q != TOP) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Single-cycle fire on the bit that completes the run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= bit_stb_i & bit_i & (run_q == LAST);
        end
    end

    assign fire_o = fire_q;

endmodule

// File: rtl/orst_reset_sequencer.sv
// Turns a power-on reset or a fire request into a soft reset pulse of
// RST_PULSE_CYC cycles followed by a lockout of LOCK_CYC cycles. busy is
// high throughout. A fire during any phase restarts the pulse.
// Assumes RST_PULSE_CYC >= 1 and LOCK_CYC >= 1.
module orst_reset_sequencer
    import orst_pkg::*;
#(
    parameter int RST_PULSE_CYC = 4,
    parameter int LOCK_CYC      = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic soft_rst_n_o,
    output logic busy_o
);

    localparam int TW = $clog2(max_of(RST_PULSE_CYC, LOCK_CYC) + 1);
    localparam logic [TW-1:0] PULSE_LOAD = TW'(RST_PULSE_CYC - 1);
    localparam logic [TW-1:0] LOCK_LOAD  = TW'(LOCK_CYC - 1);

    seq_state_t    state_q;
    logic [TW-1:0] tmr_q;

    // Phase and timer control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_PULSE;
            tmr_q   <= PULSE_LOAD;
        end else if (fire_i) begin
            state_q <= SEQ_PULSE;
            tmr_q   <= PULSE_LOAD;
        end else begin
            unique case (state_q)
                SEQ_PULSE: begin
                    if (tmr_q == '0) begin
                        state_q <= SEQ_LOCK;
                        tmr_q   <= LOCK_LOAD;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                SEQ_LOCK: begin
                    if (tmr_q == '0) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    tmr_q   <= '0;
                end
            endcase
        end
    end

    // Outputs decoded from the phase
    always_comb begin
        soft_rst_n_o = (state_q != SEQ_PULSE);
        busy_o       = (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/ones_reset_guard.sv
// Top of the ones-run reset detector. It samples the serial port, detects
// an in-band reset command made of RUN_LEN ones, sequences the soft reset
// and lockout, and gates forwarded bits and read data while busy.
// Assumes the serial clock is slow relative to clk (see sampler).
module ones_reset_guard
    import orst_pkg::*;
#(
    parameter int CLK_KHZ       = 50000,
    parameter int LOCKOUT_US    = 500,
    parameter int RUN_LEN       = 40,
    parameter int RST_PULSE_CYC = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    input  logic core_sdo_i,
    output logic sdo_o,
    output logic bit_stb_o,
    output logic bit_o,
    output logic soft_rst_n_o,
    output logic busy_o
);

    localparam int LOCK_CYC = lock_cycles(CLK_KHZ, LOCKOUT_US);

    logic raw_stb;
    logic raw_bit;
    logic fire;
    logic busy;

    orst_sclk_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk_i),
        .cs_n_i    (cs_n_i),
        .sdi_i     (sdi_i),
        .bit_stb_o (raw_stb),
        .bit_o     (raw_bit)
    );

    orst_run_detector #(
        .RUN_LEN (RUN_LEN)
    ) detector_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb_i (raw_stb),
        .bit_i     (raw_bit),
        .fire_o    (fire)
    );

    orst_reset_sequencer #(
        .RST_PULSE_CYC (RST_PULSE_CYC),
        .LOCK_CYC      (LOCK_CYC)
    ) sequencer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire_i       (fire),
        .soft_rst_n_o (soft_rst_n_o),
        .busy_o       (busy)
    );

    // Gate forwarded bits and read data during the lockout
    always_comb begin
        busy_o    = busy;
        bit_stb_o = raw_stb & ~busy;
        bit_o     = raw_bit;
        sdo_o     = busy | core_sdo_i;
    end

endmodule

// File: rtl/ones_reset_guard_chk.sv
// Property checker for ones_reset_guard, attached by bind. Window lengths
// are tracked with counters so that large parameters are not unrolled.
module ones_reset_guard_chk
    import orst_pkg::*;
#(
    parameter int CLK_KHZ       = 50000,
    parameter int LOCKOUT_US    = 500,
    parameter int RST_PULSE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic soft_rst_n_o,
    input logic busy_o,
    input logic bit_stb_o,
    input logic sdo_o
);

    localparam int LOCK_CYC = lock_cycles(CLK_KHZ, LOCKOUT_US);

    int low_run;
    int lock_run;

    // Length of the current soft reset pulse and of the current lockout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= 0;
            lock_run <= 0;
        end else begin
            low_run  <= soft_rst_n_o ? 0 : low_run + 1;
            lock_run <= !soft_rst_n_o ? 0 : (busy_o ? lock_run + 1 : 0);
        end
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_n_o) |-> (low_run == RST_PULSE_CYC)); // R1

    AST_PULSE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst_n_o |-> busy_o); // R5

    AST_LOCK_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (lock_run == LOCK_CYC)); // R6

    AST_RELEASE_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_n_o) |-> busy_o); // R6

    AST_NO_FWD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !bit_stb_o); // R7

    AST_SDO_HIGH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> sdo_o); // R7

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |=> !bit_stb_o); // R8

endmodule

bind ones_reset_guard ones_reset_guard_chk #(
    .CLK_KHZ       (CLK_KHZ),
    .LOCKOUT_US    (LOCKOUT_US),
    .RST_PULSE_CYC (RST_PULSE_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst_n_o (soft_rst_n_o),
    .busy_o       (busy_o),
    .bit_stb_o    (bit_stb_o),
    .sdo_o        (sdo_o)
);

// File: tb/ones_reset_guard_tb_top.sv
module ones_reset_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 1000;
    localparam int LOCKOUT_US = 500;
    localparam int RUN_LEN    = 40;
    localparam int PULSE      = 4;
    localparam int SYNC       = 2;
    localparam int LOCK       = CLK_KHZ * LOCKOUT_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic core_sdo = 1'b0;
    logic sdo, bit_stb, bit_val, soft_rst_n, busy;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Monitor state
    int falls = 0, stb_cnt = 0, lock_done = 0;
    int last_pulse = 0, last_lock = 0, lrun = 0, krun = 0;
    logic last_bit = 1'b0, prev_soft = 1'b0, prev_busy = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ones_reset_guard #(
        .CLK_KHZ       (CLK_KHZ),
        .LOCKOUT_US    (LOCKOUT_US),
        .RUN_LEN       (RUN_LEN),
        .RST_PULSE_CYC (PULSE),
        .SYNC_STAGES   (SYNC)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .cs_n_i       (cs_n),
        .sdi_i        (sdi),
        .core_sdo_i   (core_sdo),
        .sdo_o        (sdo),
        .bit_stb_o    (bit_stb),
        .bit_o        (bit_val),
        .soft_rst_n_o (soft_rst_n),
        .busy_o       (busy)
    );

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_soft = 1'b0;
            prev_busy = 1'b1;
            lrun = 0;
            krun = 0;
        end else begin
            if (prev_soft && !soft_rst_n) falls++;
            if (!soft_rst_n) begin
                lrun++;
            end else begin
                if (!prev_soft) last_pulse = lrun;
                lrun = 0;
            end
            if (!soft_rst_n) krun = 0;
            else if (busy) krun++;
            if (prev_busy && !busy) begin
                last_lock = krun;
                krun = 0;
                lock_done++;
            end
            if (bit_stb) begin
                stb_cnt++;
                last_bit = bit_val;
            end
            prev_soft = soft_rst_n;
            prev_busy = busy;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input bit b, input bit sel);
        @(negedge clk);
        sdi = b;
        cs_n = ~sel;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Reference model of the run counter: next run length after one bit
    function automatic int next_run(input int run, input bit b);
        if (!b) return 0;
        return (run < RUN_LEN) ? run + 1 : run;
    endfunction

    // Reference model: does this bit complete a run
    function automatic bit fires(input int run, input bit b);
        return b && (run == RUN_LEN - 1);
    endfunction

    initial begin
        int f0, s0, d0, run, exp_falls;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        check(soft_rst_n == 1'b0, "R5 soft reset low in reset", int'(soft_rst_n), 0);
        check(busy == 1'b1, "R5 busy in reset", int'(busy), 1);
        check(sdo == 1'b1, "R7 sdo high in reset", int'(sdo), 1);
        check(bit_stb == 1'b0, "R7 no strobe in reset", int'(bit_stb), 0);

        @(negedge clk);
        rst_n = 1'b1;
        wait_idle();
        check(lock_done == 1, "R5 power-up lockout completed", lock_done, 1);
        check(last_lock == LOCK, "R6 power-up lockout length", last_lock, LOCK);

        // R8: pass-through when idle
        core_sdo = 1'b0; #1;
        check(sdo == 1'b0, "R8 sdo follows core 0", int'(sdo), 0);
        core_sdo = 1'b1; #1;
        check(sdo == 1'b1, "R8 sdo follows core 1", int'(sdo), 1);
        s0 = stb_cnt;
        send_bit(1'b1, 1'b1);
        check(stb_cnt - s0 == 1, "R8 one strobe per bit", stb_cnt - s0, 1);
        check(last_bit == 1'b1, "R8 bit value 1", int'(last_bit), 1);
        send_bit(1'b0, 1'b1);
        check(stb_cnt - s0 == 2, "R8 second strobe", stb_cnt - s0, 2);
        check(last_bit == 1'b0, "R8 bit value 0", int'(last_bit), 0);

        // R4: deselected edges ignored
        s0 = stb_cnt;
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
        check(stb_cnt == s0, "R4 no strobe when deselected", stb_cnt - s0, 0);
        f0 = falls;
        send_ones(20);
        for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
        send_ones(19);
        check(falls == f0, "R4 no reset before run completes", falls - f0, 0);
        send_ones(1);
        repeat (PULSE + 4) @(negedge clk);
        check(falls == f0 + 1, "R1 R4 run of 40 fires once", falls - f0, 1);
        check(last_pulse == PULSE, "R1 pulse width", last_pulse, PULSE);

        // R7 and R3: lockout gating and saturation
        core_sdo = 1'b0; #1;
        check(busy == 1'b1, "R6 busy after pulse", int'(busy), 1);
        check(sdo == 1'b1, "R7 sdo forced high", int'(sdo), 1);
        s0 = stb_cnt;
        send_ones(3);
        check(stb_cnt == s0, "R7 transfers ignored while busy", stb_cnt - s0, 0);
        send_ones(7);
        check(falls == f0 + 1, "R3 no extra pulse on long run", falls - f0, 1);

        // R9: new command during lockout
        d0 = lock_done;
        send_bit(1'b0, 1'b1);
        send_ones(RUN_LEN);
        repeat (PULSE + 4) @(negedge clk);
        check(falls == f0 + 2, "R3 R9 new run fires again", falls - f0, 2);
        check(lock_done == d0, "R9 busy held without gap", lock_done - d0, 0);
        wait_idle();
        check(last_lock == LOCK, "R6 R9 full lockout after restart", last_lock, LOCK);

        // R2: zero clears the run
        f0 = falls;
        send_bit(1'b0, 1'b1);
        send_ones(RUN_LEN - 1);
        send_bit(1'b0, 1'b1);
        send_ones(RUN_LEN - 1);
        check(falls == f0, "R2 zero breaks the run", falls - f0, 0);
        send_ones(1);
        repeat (PULSE + 4) @(negedge clk);
        check(falls == f0 + 1, "R2 completing bit fires", falls - f0, 1);
        wait_idle();

        // Random streams against the run model
        send_bit(1'b0, 1'b1);
        run = 0;
        exp_falls = falls;
        for (int k = 0; k < 40; k++) begin
            int len;
            len = 20 + int'($urandom % 51);
            for (int j = 0; j < len; j++) begin
                bit sel, b;
                sel = ($urandom % 8) != 0;
                b = ($urandom % 16) != 0;
                send_bit(b, sel);
                if (sel) begin
                    if (fires(run, b)) exp_falls++;
                    run = next_run(run, b);
                end
            end
            repeat (PULSE + 6) @(negedge clk);
            check(falls == exp_falls, "R1 R2 R3 random pulse count", falls, exp_falls);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule